// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a small synchronous SRAM with a built-in burst address generator. Every rising clock edge samples the control pins and decodes them into one cycle type. A load cycle takes an external address and starts a read or a write burst. A continue cycle steps the two low address bits and repeats the operation that the burst started with. A cycle can also be a dummy read, a write abort, a deselect, a deselect-continue or a sleep cycle. Reads pass through one output register. The block does not drive a bidirectional pad itself. It provides the read data together with an output-enable flag, and the pad logic uses the flag to drive or release the shared data bus.

The clock enable is active low. While it is high, the clock edge has no effect: the burst counter, the burst mode, the array, the read register and the output-enable state all hold. This lets the bus master insert wait states. The output-enable and sleep inputs act combinationally on the bus-enable flag. All other inputs take effect only at a clock edge.

Top module: `sync_burst_sram`

## Requirements
- R1: A load cycle (adv_i=0, chip selected by ce1_ni=0, ce2_i=1, ce3_ni=0) with we_ni=1 and oe_ni=0 reads the word at addr_i. After that edge, dq_o carries the word and dq_oe_o is 1.
- R2: A continue cycle (adv_i=1) after a load adds 1 to the two low address bits, with 11 wrapping to 00, and leaves the upper bits unchanged. It then reads or writes at the new address, using the direction that the load cycle chose. Chip-select and we_ni are ignored on continue cycles.
- R3: On a write, a byte lane i (data bits 8i+7..8i) is written only when bw_ni[i]=0. Every other lane keeps its old contents.
- R4: A cycle with we_ni=0 and all bw_ni bits at 1 is a write abort. The array does not change, but the burst is still a write burst and the following continue cycles write.
- R5: A read cycle sampled with oe_ni=1 is a dummy read. No array access takes place, dq_oe_o stays 0 until the next cycle that performs a real read, and the burst counter still advances.
- R6: A load cycle with the chip not selected is a deselect. It sets dq_oe_o to 0, and every continue cycle after it is a deselect-continue, with no array access and the bus released. The same holds after reset.
- R7: While cke_ni=1, dq_o, dq_oe_o, the burst address and the burst direction all hold. A driven read bus stays driven, and a bus released by a write stays released.
- R8: After every write, write-abort or write-continue cycle, dq_oe_o is 0, even when oe_ni is held at 0.
- R9: oe_ni=1 forces dq_oe_o to 0 without waiting for a clock edge. Lowering oe_ni again restores the driven state.
- R10: sleep_i=1 forces dq_oe_o to 0 at once. An edge sampled while sleep_i=1 performs no array access and ends the burst, so the next continue cycle is a deselect-continue.
- R11: After reset, dq_oe_o is 0 and the core is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low; high stalls |
| adv_i | input | 1 | 0 = load external address, 1 = continue burst |
| we_ni | input | 1 | Write enable, active low (load cycles) |
| bw_ni | input | NUM_BYTES | Byte write enables, active low |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| sleep_i | input | 1 | Sleep, active high, asynchronous on the bus |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | NUM_BYTES*8 | Write data |
| dq_o | output | NUM_BYTES*8 | Registered read data |
| dq_oe_o | output | 1 | Data bus drive enable |

## Verification
A burst counter that steps wrongly or loses its upper bits shows up on the first read-continue cycle after the fault: dq_o returns the word from a neighbouring address one clock later. If the core forgets the burst direction, or forgets that it was deselected, a later continue cycle writes where it must not. That corruption only appears when the address is read back, so the bench reads back every written or protected address. A fault in stall or output-enable handling shows on dq_oe_o in the same cycle. For this reason the bus state is compared against a bench model on every cycle.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    ST_DESEL = 2'd0,
    ST_RD    = 2'd1,
    ST_WR    = 2'd2
  } bst_e;

  typedef struct packed {
    logic hold;   // edge ignored
    logic load;   // take external address
    logic step;   // advance burst counter
    logic rd;     // array read into output register
    logic wr;     // array write, byte masked
    logic drive;  // next bus drive state
    bst_e nstate;
  } ctl_t;
endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
  import sbs_pkg::*;
#(
  parameter int NUM_BYTES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cke_ni,
  input  logic                 adv_i,
  input  logic                 we_ni,
  input  logic [NUM_BYTES-1:0] bw_ni,
  input  logic                 ce1_ni,
  input  logic                 ce2_i,
  input  logic                 ce3_ni,
  input  logic                 oe_ni,
  input  logic                 sleep_i,
  input  bst_e                 state_i,
  output ctl_t                 ctl_o
);
  logic sel, any_bw;
  assign sel    = !ce1_ni && ce2_i && !ce3_ni;
  assign any_bw = !(&bw_ni);

  always_comb begin
    ctl_o        = '0;
    ctl_o.nstate = state_i;
    if (cke_ni) begin
      ctl_o.hold = 1'b1;
    end else if (sleep_i) begin
      ctl_o.nstate = ST_DESEL;
    end else if (!adv_i) begin
      if (!sel) begin
        ctl_o.nstate = ST_DESEL;
      end else if (!we_ni) begin
        ctl_o.load   = 1'b1;
        ctl_o.wr     = any_bw;
        ctl_o.nstate = ST_WR;
      end else begin
        ctl_o.load   = 1'b1;
        ctl_o.rd     = !oe_ni;
        ctl_o.drive  = !oe_ni;
        ctl_o.nstate = ST_RD;
      end
    end else begin
      unique case (state_i)
        ST_RD: begin
          ctl_o.step  = 1'b1;
          ctl_o.rd    = !oe_ni;
          ctl_o.drive = !oe_ni;
        end
        ST_WR: begin
          ctl_o.step = 1'b1;
          ctl_o.wr   = any_bw;
        end
        default: ctl_o.nstate = ST_DESEL;
      endcase
    end
  end

  p_abort_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_ni && (&bw_ni)) |-> !ctl_o.wr);
  p_desel_cont_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DESEL && adv_i) |-> (!ctl_o.rd && !ctl_o.wr && !ctl_o.drive));
  p_sleep_noacc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (!ctl_o.rd && !ctl_o.wr));
  p_dummy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !ctl_o.rd);
endmodule

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] base_q;
  logic [1:0]      cnt_q;
  logic [1:0]      cnt_nx;

  assign cnt_nx = cnt_q + 2'd1;  // linear, wraps within 4 words

  always_comb begin
    if (load_i)      addr_o = addr_i;
    else if (step_i) addr_o = {base_q, cnt_nx};
    else             addr_o = {base_q, cnt_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_i || step_i) begin
      base_q <= addr_o[ADDR_W-1:2];
      cnt_q  <= addr_o[1:0];
    end
  end

  p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (cnt_q == $past(cnt_q) + 2'd1) && $stable(base_q));
  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> ($stable(cnt_q) && $stable(base_q)));
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic                   rd_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [NUM_BYTES*8-1:0] wdata_i,
  input  logic [NUM_BYTES-1:0]   bw_ni,
  output logic [NUM_BYTES*8-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int DW    = NUM_BYTES * 8;

  logic [DW-1:0] mem [DEPTH];

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (wr_i && !bw_ni[b]) mem[addr_i][b*8 +: 8] <= wdata_i[b*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= mem[addr_i];
  end

  p_rd_wr_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && wr_i));
  p_rdata_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 2,
  localparam int DW       = NUM_BYTES * 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cke_ni,
  input  logic                 adv_i,
  input  logic                 we_ni,
  input  logic [NUM_BYTES-1:0] bw_ni,
  input  logic                 ce1_ni,
  input  logic                 ce2_i,
  input  logic                 ce3_ni,
  input  logic                 oe_ni,
  input  logic                 sleep_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        dq_o,
  output logic                 dq_oe_o
);
  bst_e              state_q;
  logic              drive_q;
  ctl_t              ctl;
  logic [ADDR_W-1:0] eff_addr;

  sbs_decode #(.NUM_BYTES(NUM_BYTES)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cke_ni  (cke_ni),
    .adv_i   (adv_i),
    .we_ni   (we_ni),
    .bw_ni   (bw_ni),
    .ce1_ni  (ce1_ni),
    .ce2_i   (ce2_i),
    .ce3_ni  (ce3_ni),
    .oe_ni   (oe_ni),
    .sleep_i (sleep_i),
    .state_i (state_q),
    .ctl_o   (ctl)
  );

  sbs_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ctl.load),
    .step_i (ctl.step),
    .addr_i (addr_i),
    .addr_o (eff_addr)
  );

  sbs_array #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES)) u_arr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ctl.wr),
    .rd_i    (ctl.rd),
    .addr_i  (eff_addr),
    .wdata_i (wdata_i),
    .bw_ni   (bw_ni),
    .rdata_o (dq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DESEL;
      drive_q <= 1'b0;
    end else if (!ctl.hold) begin
      state_q <= ctl.nstate;
      drive_q <= ctl.drive;
    end
  end

  // oe and sleep gate the bus without a clock
  assign dq_oe_o = drive_q && !oe_ni && !sleep_i;

  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> ($stable(dq_o) && $stable(drive_q) && $stable(state_q)));
  p_write_hiz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl.hold && ctl.nstate == ST_WR) |=> !drive_q);
  p_sleep_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && sleep_i) |=> (state_q == ST_DESEL && !drive_q));
endmodule

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int DW = NB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cke_n = 1'b0, adv = 1'b0, we_n = 1'b1, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic          oe_n = 1'b0, slp = 1'b0;
  logic [NB-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] dq;
  logic          dq_oe;

  int errs = 0, checks = 0;

  // bench model
  logic [DW-1:0] m_mem [1<<AW];
  int            m_st = 0;  // 0 deselected, 1 read burst, 2 write burst
  logic [AW-3:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic          m_drive = 1'b0;
  logic [DW-1:0] m_rdq = '0;

  always #2 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .NUM_BYTES(NB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cke_ni(cke_n), .adv_i(adv), .we_ni(we_n),
    .bw_ni(bw_n), .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n), .oe_ni(oe_n),
    .sleep_i(slp), .addr_i(addr), .wdata_i(wdata), .dq_o(dq), .dq_oe_o(dq_oe)
  );

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [NB-1:0] m);
    logic [DW-1:0] r = old;
    for (int b = 0; b < NB; b++) if (!m[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  task automatic model_edge();
    logic [AW-1:0] a;
    if (cke_n) return;
    if (slp) begin m_st = 0; m_drive = 1'b0; return; end
    if (!adv) begin
      if (!(!ce1_n && ce2 && !ce3_n)) begin m_st = 0; m_drive = 1'b0; return; end
      m_base = addr[AW-1:2]; m_cnt = addr[1:0];
      m_st = we_n ? 1 : 2;
    end else begin
      if (m_st == 0) begin m_drive = 1'b0; return; end
      m_cnt = m_cnt + 2'd1;
    end
    a = {m_base, m_cnt};
    if (m_st == 2) begin
      m_drive = 1'b0;
      m_mem[a] = merge(m_mem[a], wdata, bw_n);
    end else begin
      m_drive = !oe_n;
      if (!oe_n) m_rdq = m_mem[a];
    end
  endtask

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_model(string tag);
    logic e_oe = m_drive && !oe_n && !slp;
    chk({tag, " bus enable"}, DW'(dq_oe), DW'(e_oe));
    if (e_oe) chk({tag, " data"}, dq, m_rdq);
  endtask

  // drive at negedge, edge, return at next negedge
  task automatic cyc(logic c_n, logic ad, logic w_n, logic [NB-1:0] b_n, logic sel,
                     logic o_n, logic s, logic [AW-1:0] a, logic [DW-1:0] d);
    cke_n = c_n; adv = ad; we_n = w_n; bw_n = b_n;
    ce1_n = !sel; ce2 = sel; ce3_n = !sel;
    oe_n = o_n; slp = s; addr = a; wdata = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic rd_ld(logic [AW-1:0] a);  cyc(0, 0, 1, '1, 1, 0, 0, a, '0); endtask
  task automatic rd_nx();                  cyc(0, 1, 1, '1, 1, 0, 0, '0, '0); endtask
  task automatic wr_ld(logic [AW-1:0] a, logic [DW-1:0] d, logic [NB-1:0] m);
    cyc(0, 0, 0, m, 1, 0, 0, a, d);
  endtask
  task automatic wr_nx(logic [DW-1:0] d, logic [NB-1:0] m); cyc(0, 1, 1, m, 1, 0, 0, '0, d); endtask

  initial begin
    #200000;
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset bus enable", DW'(dq_oe), '0);
    rst_n = 1'b1;
    @(negedge clk);
    cyc(0, 1, 1, '1, 1, 0, 0, '0, '0);
    chk("R11 continue after reset stays released", DW'(dq_oe), '0);

    for (int i = 0; i < (1<<AW); i++) wr_ld(AW'(i), DW'(16'h1000 + i * 16'h0101), '0);

    // R2/R8 write burst with wrap
    wr_ld(6'h04, 16'h1111, '0);
    chk("R8 write load releases bus", DW'(dq_oe), '0);
    wr_nx(16'h2222, '0); wr_nx(16'h3333, '0); wr_nx(16'h4444, '0);
    wr_nx(16'h5555, '0);
    chk("R8 write continue releases bus", DW'(dq_oe), '0);
    rd_ld(6'h06);
    chk("R1 read load data", dq, 16'h3333);
    chk("R1 read load drives", DW'(dq_oe), 1);
    rd_nx();
    chk("R2 read continue next", dq, 16'h4444);
    rd_nx();
    chk("R2 read continue wraps to 4", dq, 16'h5555);
    // R7 stall with read bus
    for (int k = 0; k < 3; k++) begin
      cyc(1, 0, 0, '0, 1, 0, 0, 6'h3f, 16'hdead);
      chk("R7 stall holds read data", dq, 16'h5555);
      chk("R7 stall keeps bus driven", DW'(dq_oe), 1);
    end
    rd_nx();
    chk("R7 counter held over stall", dq, 16'h2222);
    // R9 asynchronous output enable
    oe_n = 1'b1; #1;
    chk("R9 oe high releases at once", DW'(dq_oe), '0);
    oe_n = 1'b0; #1;
    chk("R9 oe low drives again", DW'(dq_oe), 1);
    @(negedge clk);

    // R3 byte mask
    wr_ld(6'h05, 16'hAAAA, 2'b10);
    rd_ld(6'h05);
    chk("R3 only lane 0 written", dq, 16'h22AA);
    wr_ld(6'h05, 16'hBBBB, 2'b01);
    rd_ld(6'h05);
    chk("R3 only lane 1 written", dq, 16'hBBAA);

    // R4 write abort, burst stays a write burst
    wr_ld(6'h08, 16'h0808, '0);
    wr_ld(6'h08, 16'hFFFF, '1);
    chk("R4 abort releases bus", DW'(dq_oe), '0);
    wr_nx(16'h0909, '0);
    rd_ld(6'h08);
    chk("R4 abort left array unchanged", dq, 16'h0808);
    rd_nx();
    chk("R4 continue after abort wrote", dq, 16'h0909);
    // R7 stall after write keeps bus released
    wr_ld(6'h10, 16'h1010, '0);
    cyc(1, 1, 1, '1, 1, 0, 0, '0, '0);
    chk("R7 stall after write stays released", DW'(dq_oe), '0);

    // R5 dummy read
    cyc(0, 0, 1, '1, 1, 1, 0, 6'h08, '0);
    oe_n = 1'b0; #1;
    chk("R5 dummy read keeps bus released", DW'(dq_oe), '0);
    @(negedge clk);
    rd_nx();
    chk("R5 counter advanced over dummy read", dq, 16'h0909);

    // R6 deselect then continue must not write
    wr_ld(6'h0C, 16'h0C0C, '0);
    wr_nx(16'h0D0D, '0);
    cyc(0, 0, 0, '0, 0, 0, 0, 6'h0C, 16'hDEAD);
    chk("R6 deselect releases bus", DW'(dq_oe), '0);
    wr_nx(16'hDEAD, '0); wr_nx(16'hDEAD, '0);
    chk("R6 deselect continue releases bus", DW'(dq_oe), '0);
    rd_ld(6'h0C);
    chk("R6 no write after deselect", dq, 16'h0C0C);
    rd_nx();
    chk("R6 no write after deselect +1", dq, 16'h0D0D);

    // R10 sleep
    rd_ld(6'h0C);
    slp = 1'b1; #1;
    chk("R10 sleep releases at once", DW'(dq_oe), '0);
    @(negedge clk);
    cyc(0, 1, 1, '1, 1, 0, 1, '0, '0);
    cyc(0, 0, 0, '0, 1, 0, 1, 6'h0C, 16'hBEEF);
    cyc(0, 1, 1, '1, 1, 0, 0, '0, '0);
    chk("R10 burst ended by sleep", DW'(dq_oe), '0);
    rd_ld(6'h0C);
    chk("R10 no write while asleep", dq, 16'h0C0C);

    // random phase against the model
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 3000; n++) begin
      cyc(($urandom % 8) == 0, $urandom % 2, $urandom % 2, NB'($urandom),
          ($urandom % 8) != 0, ($urandom % 8) == 0, ($urandom % 32) == 0,
          AW'($urandom), DW'($urandom));
      chk_model("R2 random");
    end
    for (int i = 0; i < (1<<AW); i++) begin
      rd_ld(AW'(i));
      chk("R3 random final contents", dq, m_mem[i]);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule